// File: doc/BRIEF.md
# SDRAM Row-Open Access Sequencer

This block turns one read or write request on a flat word address into the command sequence for a four-bank SDRAM with 32-bit words. For each accepted request it splits the address into bank, row and column. It opens the row, waits the activate-to-column delay, and issues the column command. It then lets the programmed number of burst beats pass, closes the bank again and waits out the precharge time before it takes the next request.

The user side is a valid/ready handshake with a write flag and a two-bit burst code. The memory side carries chip select, the three strobes, the bank pins and the shared address pins. Every memory output comes straight from a flop, so it changes only on a rising clock edge. A request presented while an access is running is not lost. It waits until ready returns and is accepted on that cycle.

Top module: `sdram_row_seq`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and sd_cs_n is 1, meaning the memory is deselected.
- R2: In the cycle after a request is accepted, an ACTIVE command is on the pins. sd_ba carries address bits 22:21 (the bank) and sd_a carries address bits 20:9 (the row).
- R3: Commands use {sd_ras_n,sd_cas_n,sd_we_n} with sd_cs_n low. The codes are ACTIVE=011, READ=101, WRITE=100, PRECHARGE=010 and NOP=111. When no access is active and none is starting, sd_cs_n is 1.
- R4: Exactly T_RCD NOP cycles (default 2) lie between ACTIVE and the column command.
- R5: The column command drives address bits 8:0 on sd_a[8:0] and zeros on sd_a[11:9]. It uses the bank that was opened.
- R6: A request with req_write=1 produces WRITE. A request with req_write=0 produces READ.
- R7: The burst code sets the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. After the column command come (length-1) NOP cycles, then PRECHARGE.
- R8: PRECHARGE goes to the bank that was opened, with sd_a all zero, so A10 is low.
- R9: After PRECHARGE, exactly T_RP NOP cycles follow (default 2). req_ready goes high and done pulses high for one cycle during the last of them.
- R10: A request is taken only on a clock edge where req_valid and req_ready are both high. req_ready is low from the cycle after acceptance until R9 ends. A request held during that time is accepted as soon as req_ready returns, so its ACTIVE follows the last NOP directly.
- R11: Each accepted request produces exactly one ACTIVE, one column command and one PRECHARGE. A bank is never activated while a row is still open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_addr | input | 23 | Flat word address: bank 22:21, row 20:9, column 8:0 |
| req_burst | input | 2 | Burst length code (1, 2, 4, 8 beats) |
| done | output | 1 | One-cycle pulse as the access finishes |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Shared row/column address pins |

## Verification
The assertions check on every cycle that a column command only comes to an open row, after exactly T_RCD NOPs and on the opened bank. They also check that precharge closes that same bank with A10 low, that no activate lands on an open row, and that ready never coincides with an activate, column or precharge command. Only the bench scenarios can show the address field split, the read/write choice, the exact beat count for each burst code, and the full timing of the sequence. The same applies to a held request being taken at once when ready returns. The bench shows these by comparing every selected cycle against an expected pin stream.

// File: rtl/sdram_row_seq.sv
module sdram_row_seq #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [1:0]                    req_burst,
  output logic                          done,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_a
);

  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int TMAX   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int CMAX   = (TMAX > 8) ? TMAX : 8;
  localparam int CW     = $clog2(CMAX + 1);

  localparam logic [2:0] CMD_ACT = 3'b011;
  localparam logic [2:0] CMD_RD  = 3'b101;
  localparam logic [2:0] CMD_WR  = 3'b100;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_NOP = 3'b111;

  typedef enum logic [1:0] {S_IDLE, S_RCD, S_BURST, S_RP} state_t;

  state_t            state;
  logic [2:0]        cmd;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     beats_m1;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  logic [CW-1:0]     burst_m1;

  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  always_comb begin
    case (req_burst)
      2'd0:    burst_m1 = CW'(0);
      2'd1:    burst_m1 = CW'(1);
      2'd2:    burst_m1 = CW'(3);
      default: burst_m1 = CW'(7);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      req_ready <= 1'b1;
      done      <= 1'b0;
      sd_cs_n   <= 1'b1;
      cmd       <= CMD_NOP;
      sd_ba     <= '0;
      sd_a      <= '0;
      cnt       <= '0;
      beats_m1  <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            sd_cs_n   <= 1'b0;
            cmd       <= CMD_ACT;
            sd_ba     <= req_addr[ADDR_W-1 -: BANK_W];
            sd_a      <= req_addr[COL_W +: ROW_W];
            col_q     <= req_addr[COL_W-1:0];
            wr_q      <= req_write;
            beats_m1  <= burst_m1;
            cnt       <= CW'(T_RCD);
            req_ready <= 1'b0;
            state     <= S_RCD;
          end else begin
            sd_cs_n <= 1'b1;
            cmd     <= CMD_NOP;
          end
        end
        S_RCD: begin
          if (cnt != '0) begin
            cmd <= CMD_NOP;
            cnt <= cnt - 1'b1;
          end else begin
            cmd   <= wr_q ? CMD_WR : CMD_RD;
            sd_a  <= {{(ROW_W-COL_W){1'b0}}, col_q};
            cnt   <= beats_m1;
            state <= S_BURST;
          end
        end
        S_BURST: begin
          if (cnt != '0) begin
            cmd <= CMD_NOP;
            cnt <= cnt - 1'b1;
          end else begin
            cmd   <= CMD_PRE;
            sd_a  <= '0;
            cnt   <= CW'(T_RP);
            state <= S_RP;
          end
        end
        default: begin
          cmd <= CMD_NOP;
          if (cnt > CW'(1)) begin
            cnt <= cnt - 1'b1;
          end else begin
            state     <= S_IDLE;
            req_ready <= 1'b1;
            done      <= 1'b1;
          end
        end
      endcase
    end
  end

  logic is_act, is_col, is_pre, is_nop;
  assign is_act = !sd_cs_n && cmd == CMD_ACT;
  assign is_col = !sd_cs_n && (cmd == CMD_RD || cmd == CMD_WR);
  assign is_pre = !sd_cs_n && cmd == CMD_PRE;
  assign is_nop = !sd_cs_n && cmd == CMD_NOP;

  logic              row_open;
  logic [CW:0]       gap;
  logic [BANK_W-1:0] open_ba;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      gap      <= '0;
      open_ba  <= '0;
    end else begin
      if (is_act) begin
        row_open <= 1'b1;
        gap      <= '0;
        open_ba  <= sd_ba;
      end else if (is_nop && gap != '1) begin
        gap <= gap + 1'b1;
      end else if (is_col) begin
        gap <= '1;
      end
      if (is_pre) row_open <= 1'b0;
    end
  end

  p_col_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> row_open && gap == (CW+1)'(T_RCD));

  p_col_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> sd_ba == open_ba && sd_a[ROW_W-1:COL_W] == '0);

  p_pre_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> row_open && sd_ba == open_ba && sd_a == '0);

  p_act_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !row_open);

  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && is_nop);

  p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sd_cs_n || cmd == CMD_NOP));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> (!req_ready && is_act));

endmodule

// File: tb/sdram_row_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_row_seq_tb_top;
  localparam int TRCD = 2;
  localparam int TRP  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [1:0]  req_burst = '0;
  logic        req_ready, done, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;

  always #2 clk = ~clk;

  sdram_row_seq #(.T_RCD(TRCD), .T_RP(TRP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_burst(req_burst),
    .done(done), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a));

  typedef struct {
    logic [2:0]  cmd;
    logic        chk_addr;
    logic [1:0]  ba;
    logic [11:0] a;
    logic        rdy;
    logic        dn;
    string       rq;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int failures = 0;
  int acts_seen = 0;
  int reqs_sent = 0;
  bit finished = 1'b0;

  task automatic push(input logic [2:0] c, input logic ck, input logic [1:0] b,
                      input logic [11:0] a, input logic r, input logic d, input string rq);
    item_t it;
    it.cmd = c; it.chk_addr = ck; it.ba = b; it.a = a; it.rdy = r; it.dn = d; it.rq = rq;
    exp_q.push_back(it);
  endtask

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, got, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [22:0] ad, input logic [1:0] bs);
    int bl;
    bl = 1 << bs;
    reqs_sent++;
    push(3'b011, 1'b1, ad[22:21], ad[20:9], 1'b0, 1'b0, "R2");
    for (int i = 0; i < TRCD; i++) push(3'b111, 1'b0, '0, '0, 1'b0, 1'b0, "R4");
    push(wr ? 3'b100 : 3'b101, 1'b1, ad[22:21], {3'b000, ad[8:0]}, 1'b0, 1'b0,
         wr ? "R6_R5" : "R6_R5_rd");
    for (int i = 1; i < bl; i++) push(3'b111, 1'b0, '0, '0, 1'b0, 1'b0, "R7");
    push(3'b010, 1'b1, ad[22:21], 12'h000, 1'b0, 1'b0, "R8");
    for (int i = 1; i < TRP; i++) push(3'b111, 1'b0, '0, '0, 1'b0, 1'b0, "R9");
    push(3'b111, 1'b0, '0, '0, 1'b1, 1'b1, "R9");
    req_write = wr; req_addr = ad; req_burst = bs; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!sd_cs_n) begin
        if ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b011) acts_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected command", {sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check({sd_ras_n, sd_cas_n, sd_we_n} == e.cmd, (e.cmd == 3'b111) ? e.rq : "R3",
                "cmd", {sd_ras_n, sd_cas_n, sd_we_n}, e.cmd);
          if (e.chk_addr)
            check(sd_ba == e.ba && sd_a == e.a, e.rq, "ba/a", {sd_ba, sd_a}, {e.ba, e.a});
          check(req_ready == e.rdy && done == e.dn, "R9", "ready/done",
                {req_ready, done}, {e.rdy, e.dn});
        end
      end else begin
        check(req_ready && !done, "R10", "idle ready/done", {req_ready, done}, 2'b10);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !done && sd_cs_n, "R1", "reset outputs",
          {req_ready, done, sd_cs_n}, 3'b101);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done && sd_cs_n, "R1", "after reset",
          {req_ready, done, sd_cs_n}, 3'b101);
    access(1'b0, {2'd1, 12'h2A5, 9'h13C}, 2'd0);
    repeat (12) @(negedge clk);
    access(1'b1, {2'd2, 12'h001, 9'h0FF}, 2'd3);
    repeat (15) @(negedge clk);
    access(1'b0, {2'd3, 12'hFFF, 9'h1FF}, 2'd1);
    // back-to-back: second request held while the first runs (R10)
    access(1'b1, {2'd0, 12'h000, 9'h000}, 2'd2);
    access(1'b0, {2'd2, 12'h5A5, 9'h0A5}, 2'd0);
    access(1'b1, {2'd1, 12'h800, 9'h100}, 2'd1);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R11", "pending items", exp_q.size(), 0);
    check(acts_seen == reqs_sent, "R11", "activate count", acts_seen, reqs_sent);
    check(req_ready && sd_cs_n, "R10", "final idle", {req_ready, sd_cs_n}, 2'b11);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule